// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block guards a processor against a hang. Software programs two period codes and a response mode, then sets the enable bit. From that moment a down counter runs once per clock and must be reloaded ("kicked") before it reaches zero. There are two kinds of kick: a write of the magic byte 0x76 to the kick register, or a read of the interrupt-clear register. A write of any other byte is not a kick.

On expiry the block does one of two things. In direct mode it raises a system reset request. In two-stage mode it first raises an interrupt and reloads the counter for a grace countdown, and it requests the reset only if that second countdown also runs out. The reset request stays raised until the system reset (`rst_n`) arrives. That reset returns the block to the disabled state, where it waits for software to set it up again.

The state machine has four states:
- OFF (disabled).
- RUN (first countdown).
- GRACE (second countdown, interrupt pending).
- TRIP (reset requested).

It has these transitions:
- OFF→RUN on the enable write, which loads the initial period.
- RUN→RUN on a kick, which loads the restart period.
- RUN→GRACE on expiry in two-stage mode, which sets the interrupt and loads the restart period.
- RUN→TRIP on expiry in direct mode.
- GRACE→RUN on a kick, which loads the restart period.
- GRACE→TRIP on expiry.
- TRIP→OFF only through `rst_n`.

Top module: `wdt_two_stage`

## Requirements
- R1: After `rst_n` is low, `wdt_irq` and `wdt_rst_req` are 0 and the control and period registers read back 0.
- R2: Register map (addresses on `reg_addr`):
  - Address 0 is control: bit0 enable, bit1 mode (1 = two-stage).
  - Address 1 holds the period codes: bits [3:0] initial code i, bits [7:4] restart code r.
  - Address 2 is the kick register.
  - Address 3 is the interrupt-clear register.

  A period is 2^(S+code) clocks, with S = `BASE_SHIFT`. In direct mode, `wdt_rst_req` first reads 1 exactly 2^(S+i) clocks after the edge that takes the enable write.
- R3: In two-stage mode, `wdt_irq` rises 2^(S+i) clocks after the enable edge and `wdt_rst_req` rises 2^(S+r) clocks later. Neither rises before its time.
- R4: A write of 0x76 to address 2 in RUN or GRACE reloads the restart period. The next expiry comes 2^(S+r) clocks after the kick edge.
- R5: A write of any value other than 0x76 to address 2 has no effect on the countdown.
- R6: A read of address 3 in RUN or GRACE reloads the restart period, as in R4.
- R7: A kick in GRACE returns the block to RUN. A 0x76 kick leaves `wdt_irq` set, so the next expiry goes to GRACE again and the reset request follows one restart period later.
- R8: A read of address 3 returns `wdt_irq` in bit0 and clears `wdt_irq` at the same edge that reloads the counter.
- R9: Once enabled, the enable bit cannot be cleared by software. Writing 0 to it neither stops nor delays the countdown.
- R10: In OFF, kicks are ignored and both outputs stay 0.
- R11: A kick on the same edge as an expiry wins: the counter reloads and no expiry action takes place.
- R12: The control and period registers read back what was written. The mode bit can be written without enabling the timer.
- R13: Once raised, `wdt_rst_req` holds through any kick until `rst_n`, after which the block is OFF with enable clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, also the response to a reset request |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| wdt_irq | output | 1 | Expiry interrupt, held until address 3 is read |
| wdt_rst_req | output | 1 | System reset request, held until `rst_n` |

## Verification
The hardest case to reach is a kick that lands on the very edge where the counter is at zero, the R11 race. The bench reaches it by counting edges from the enable write and placing the kick strobe on edge number 2^(S+i). It then measures the full restart period from that edge.

The grace-stage paths need similar care. The bench waits for the interrupt edge and then issues the kick or the clear read one edge later, which makes the two kinds of kick behave visibly differently. All periods are kept short by building the bench with a small `BASE_SHIFT`, so that whole code ranges can be swept.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_GRACE = 2'd2,
        ST_TRIP  = 2'd3
    } wdt_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_TOUT = 2'd1;
    localparam logic [1:0] ADDR_KICK = 2'd2;
    localparam logic [1:0] ADDR_ICLR = 2'd3;

    localparam logic [7:0] KICK_MAGIC = 8'h76;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs #(
    parameter int BASE_SHIFT = 16,
    parameter int CNT_W      = BASE_SHIFT + 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic             irq,
    output logic [7:0]       reg_rdata,
    output logic             start,
    output logic             mode,
    output logic             kick,
    output logic             clr,
    output logic [CNT_W-1:0] init_last,
    output logic [CNT_W-1:0] rest_last
);
    import wdt_pkg::*;

    logic       en_q;
    logic       mode_q;
    logic [3:0] init_code;
    logic [3:0] rest_code;

    function automatic logic [CNT_W-1:0] last_count(input logic [3:0] code);
        return (CNT_W'(1) << (BASE_SHIFT + int'(code))) - CNT_W'(1);
    endfunction

    wire ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
    wire tout_wr = reg_wr && (reg_addr == ADDR_TOUT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            mode_q    <= 1'b0;
            init_code <= '0;
            rest_code <= '0;
        end else begin
            if (ctrl_wr) begin
                en_q   <= en_q | reg_wdata[0];
                mode_q <= reg_wdata[1];
            end
            if (tout_wr) begin
                init_code <= reg_wdata[3:0];
                rest_code <= reg_wdata[7:4];
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = {6'b0, mode_q, en_q};
            ADDR_TOUT: reg_rdata = {rest_code, init_code};
            ADDR_KICK: reg_rdata = 8'h00;
            ADDR_ICLR: reg_rdata = {7'b0, irq};
            default:   reg_rdata = 8'h00;
        endcase
    end

    assign start     = ctrl_wr && reg_wdata[0] && !en_q;
    assign mode      = mode_q;
    assign clr       = reg_rd && (reg_addr == ADDR_ICLR);
    assign kick      = clr || (reg_wr && (reg_addr == ADDR_KICK) && (reg_wdata == KICK_MAGIC));
    assign init_last = last_count(init_code);
    assign rest_last = last_count(rest_code);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               kick,
    input  logic               clr,
    input  logic               zero,
    input  logic               mode,
    output wdt_pkg::wdt_state_e state,
    output logic               load,
    output logic               load_rest,
    output logic               run,
    output logic               irq,
    output logic               rst_req
);
    import wdt_pkg::*;

    wdt_state_e nxt;
    logic       irq_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt       = state;
        load      = 1'b0;
        load_rest = 1'b0;
        irq_set   = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (start) begin
                    nxt  = ST_RUN;
                    load = 1'b1;
                end
            end
            ST_RUN: begin
                if (kick) begin
                    load      = 1'b1;
                    load_rest = 1'b1;
                end else if (zero && mode) begin
                    nxt       = ST_GRACE;
                    load      = 1'b1;
                    load_rest = 1'b1;
                    irq_set   = 1'b1;
                end else if (zero) begin
                    nxt = ST_TRIP;
                end
            end
            ST_GRACE: begin
                if (kick) begin
                    nxt       = ST_RUN;
                    load      = 1'b1;
                    load_rest = 1'b1;
                end else if (zero) begin
                    nxt = ST_TRIP;
                end
            end
            ST_TRIP: nxt = ST_TRIP;
            default: nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       irq <= 1'b0;
        else if (clr)     irq <= 1'b0;
        else if (irq_set) irq <= 1'b1;
    end

    assign run     = (state == ST_RUN) || (state == ST_GRACE);
    assign rst_req = (state == ST_TRIP);

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
    parameter int BASE_SHIFT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       wdt_irq,
    output logic       wdt_rst_req
);
    import wdt_pkg::*;

    localparam int CNT_W = BASE_SHIFT + 16;

    logic             start, mode, kick, clr;
    logic [CNT_W-1:0] init_last, rest_last, load_val, cnt;
    logic             load, load_rest, run, zero;
    wdt_state_e       state;

    wdt_regs #(.BASE_SHIFT(BASE_SHIFT), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .irq       (wdt_irq),
        .reg_rdata (reg_rdata),
        .start     (start),
        .mode      (mode),
        .kick      (kick),
        .clr       (clr),
        .init_last (init_last),
        .rest_last (rest_last)
    );

    wdt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .kick      (kick),
        .clr       (clr),
        .zero      (zero),
        .mode      (mode),
        .state     (state),
        .load      (load),
        .load_rest (load_rest),
        .run       (run),
        .irq       (wdt_irq),
        .rst_req   (wdt_rst_req)
    );

    assign load_val = load_rest ? rest_last : init_last;

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .run      (run),
        .cnt      (cnt),
        .zero     (zero)
    );

endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [1:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    input  logic               wdt_irq,
    input  logic               wdt_rst_req,
    input  wdt_pkg::wdt_state_e state,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [CNT_W-1:0]   rest_last
);
    import wdt_pkg::*;

    wire live      = (state == ST_RUN) || (state == ST_GRACE);
    wire good_kick = reg_wr && (reg_addr == ADDR_KICK) && (reg_wdata == KICK_MAGIC);
    wire bad_kick  = reg_wr && (reg_addr == ADDR_KICK) && (reg_wdata != KICK_MAGIC);
    wire clr_rd    = reg_rd && (reg_addr == ADDR_ICLR);

    AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |=> wdt_rst_req); // R13
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> (!wdt_irq && !wdt_rst_req)); // R10
    AST_CLR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rd |=> !wdt_irq); // R8
    AST_BAD_KICK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_kick && (state == ST_RUN) && (cnt != '0)) |=> (cnt == $past(cnt) - CNT_W'(1))); // R5
    AST_GOOD_KICK_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (good_kick && live) |=> (cnt == $past(rest_last))); // R4
    AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF) |=> (state != ST_OFF)); // R9
    AST_IRQ_PRECEDES_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_irq) |-> !wdt_rst_req); // R3

endmodule

bind wdt_two_stage wdt_two_stage_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .wdt_irq     (wdt_irq),
    .wdt_rst_req (wdt_rst_req),
    .state       (state),
    .cnt         (cnt),
    .rest_last   (rest_last)
);

// File: tb/sim_wdt_two_stage.sv
`timescale 1ns/1ps
module sim_wdt_two_stage;
    localparam int S = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       wdt_irq;
    logic       wdt_rst_req;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wdt_two_stage #(.BASE_SHIFT(S)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req)
    );

    function automatic int per(input int code);
        return 1 << (S + code);
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] a, output int d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = int'(reg_rdata);
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic edges(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    // which: 0 irq, 1 reset request; n = edges elapsed since last strobe edge
    task automatic wait_sig(input bit which, input int limit, output int n);
        n = 0;
        while (((which ? wdt_rst_req : wdt_irq) == 1'b0) && (n < limit)) begin
            @(posedge clk); @(negedge clk);
            n++;
        end
    endtask

    task automatic arm(input bit md, input int ci, input int cr);
        do_wr(2'd1, {4'(cr), 4'(ci)});
        do_wr(2'd0, {6'b0, md, 1'b1});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, d;
        do_reset();
        // R1 reset state
        check(int'(wdt_irq), 0, "R1 irq");
        check(int'(wdt_rst_req), 0, "R1 rst_req");
        do_rd(2'd0, d); check(d, 0, "R1 ctrl");
        do_rd(2'd1, d); check(d, 0, "R1 tout");

        // R12 readback, mode writable without enable
        do_wr(2'd1, 8'hA5); do_rd(2'd1, d); check(d, 8'hA5, "R12 tout");
        do_wr(2'd0, 8'h02); do_rd(2'd0, d); check(d, 2, "R12 ctrl mode only");
        // R10 kicks ignored while off
        do_wr(2'd2, 8'h76); do_rd(2'd3, d); edges(600);
        check(int'(wdt_rst_req), 0, "R10 rst_req");
        check(int'(wdt_irq), 0, "R10 irq");

        // R2 direct-mode expiry over init codes
        for (int ci = 0; ci < 8; ci++) begin
            do_reset();
            arm(1'b0, ci, 0);
            wait_sig(1'b1, 4096, n);
            check(n, per(ci), $sformatf("R2 init code %0d", ci));
            check(int'(wdt_irq), 0, "R2 no irq");
        end

        // R13 reset request holds through kicks, cleared by rst_n
        do_wr(2'd2, 8'h76); do_rd(2'd3, d); edges(20);
        check(int'(wdt_rst_req), 1, "R13 held");
        do_reset();
        check(int'(wdt_rst_req), 0, "R13 cleared");
        do_rd(2'd0, d); check(d, 0, "R13 back to off");

        // R3 two-stage sweep
        for (int ci = 0; ci < 4; ci++) begin
            for (int cr = 0; cr < 4; cr++) begin
                do_reset();
                arm(1'b1, ci, cr);
                wait_sig(1'b0, 4096, n);
                check(n, per(ci), $sformatf("R3 irq i=%0d r=%0d", ci, cr));
                check(int'(wdt_rst_req), 0, "R3 no early rst");
                wait_sig(1'b1, 4096, n);
                check(n, per(cr), $sformatf("R3 rst i=%0d r=%0d", ci, cr));
            end
        end

        // R4 magic kick at several points
        for (int cr = 0; cr < 4; cr++) begin
            for (int k = 1; k < per(3); k += 7) begin
                do_reset();
                arm(1'b0, 3, cr);
                edges(k - 1);
                do_wr(2'd2, 8'h76);
                wait_sig(1'b1, 4096, n);
                check(n, per(cr), $sformatf("R4 kick r=%0d k=%0d", cr, k));
            end
        end

        // R5 non-magic writes ignored
        do_reset();
        arm(1'b0, 4, 0);
        do_wr(2'd2, 8'h75); do_wr(2'd2, 8'h00); do_wr(2'd2, 8'hF6); do_wr(2'd2, 8'h77);
        wait_sig(1'b1, 4096, n);
        check(n + 4, per(4), "R5 bad values ignored");

        // R6 clear-register read reloads in RUN
        do_reset();
        arm(1'b0, 4, 1);
        edges(10);
        do_rd(2'd3, d);
        check(d, 0, "R6 read data no irq");
        wait_sig(1'b1, 4096, n);
        check(n, per(1), "R6 read reload");

        // R7 magic kick in GRACE: back to RUN, irq stays
        do_reset();
        arm(1'b1, 1, 2);
        wait_sig(1'b0, 4096, n);
        do_wr(2'd2, 8'h76);
        check(int'(wdt_irq), 1, "R7 irq stays");
        wait_sig(1'b1, 4096, n);
        check(n, 2 * per(2), "R7 grace kick");

        // R8 clear read in GRACE
        do_reset();
        arm(1'b1, 1, 2);
        wait_sig(1'b0, 4096, n);
        do_rd(2'd3, d);
        check(d, 1, "R8 read data irq");
        check(int'(wdt_irq), 0, "R8 cleared same edge");
        wait_sig(1'b0, 4096, n);
        check(n, per(2), "R8 irq again after restart period");
        wait_sig(1'b1, 4096, n);
        check(n, per(2), "R8 rst after grace");

        // R9 enable cannot be cleared
        do_reset();
        arm(1'b0, 3, 0);
        do_wr(2'd0, 8'h00);
        do_rd(2'd0, d);
        check(d & 1, 1, "R9 enable sticky");
        wait_sig(1'b1, 4096, n);
        check(n + 2, per(3), "R9 countdown kept");

        // R11 kick on the expiry edge wins
        for (int cr = 0; cr < 3; cr++) begin
            do_reset();
            arm(1'b1, 2, cr);
            edges(per(2) - 1);
            do_wr(2'd2, 8'h76);
            check(int'(wdt_irq), 0, "R11 no irq on race");
            wait_sig(1'b0, 4096, n);
            check(n, per(cr), $sformatf("R11 race r=%0d", cr));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule